// File: doc/BRIEF.md
# Configurable Split Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a multi-threaded signal-processing core. Every product is built from four signed 17x17 partial multipliers whose outputs are merged by a post-multiply combiner. The same array therefore serves four operand shapes: a single halfword product, a pair of independent halfword products, a 31-bit signed product and a full 32-bit signed product.

A product can be returned directly or folded into a 40-bit accumulator. The accumulator bank holds one private entry per hardware thread plus a group of entries that every thread may address. Accumulation wraps modulo 2^40 or, on request, clamps to the signed 40-bit range. The unit is pipelined in two stages (partial multiply, then combine and accumulate), and consecutive operations on the same accumulator proceed every cycle without a stall.

Top module: `split_mac`

## Requirements
- R1: An operation sampled with `in_valid` high produces `out_valid` high with its `result` exactly two rising clock edges later; `out_valid` is low in every other cycle. Synchronous reset clears `out_valid`, `result` and all accumulators to zero.
- R2: With `op_mode` = 0 and `acc_op` = 0, `result` is the signed product of `opa[15:0]` and `opb[15:0]`, sign-extended to 64 bits; bits 31:16 of both operands are ignored.
- R3: With `op_mode` = 1 and `acc_op` = 0, `result[31:0]` is the signed product of the low halfwords and `result[63:32]` is the signed product of the high halfwords (`opa[31:16]` times `opb[31:16]`).
- R4: With `op_mode` = 2 and `acc_op` = 0, the operands are the signed 31-bit values in bits 30:0 (bit 30 is the sign, bit 31 is ignored) and `result` is their product sign-extended to 64 bits.
- R5: With `op_mode` = 3 and `acc_op` = 0, `result` is the full 64-bit signed product of `opa` and `opb`.
- R6: `acc_op` encodes 0 = no accumulator access, 1 = add, 2 = subtract, 3 = load. Add/subtract combine the selected accumulator with the addend; load replaces it with the addend. The addend is the low 40 bits of the product, or in `op_mode` = 1 the sum of the two halfword products. An accumulating operation returns the new accumulator value sign-extended to 64 bits; `acc_op` = 0 leaves every accumulator unchanged.
- R7: `acc_sel` = 0 addresses the private accumulator of thread `thread_id`; `acc_sel` = 1 to 3 addresses shared accumulator 1 to 3, which is the same storage for every thread.
- R8: With `sat_en` low, add/subtract results wrap modulo 2^40 (two's complement).
- R9: With `sat_en` high, an add/subtract result above 2^39-1 becomes 2^39-1 and one below -2^39 becomes -2^39.
- R10: An operation accepted in the cycle after another on the same accumulator sees the earlier update, with no stall and no lost update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_mode | input | 2 | 0 halfword, 1 dual halfword, 2 31-bit, 3 32-bit |
| thread_id | input | 2 | Issuing thread |
| acc_sel | input | 2 | 0 private accumulator, 1-3 shared accumulator |
| acc_op | input | 2 | 0 none, 1 add, 2 subtract, 3 load |
| sat_en | input | 1 | Clamp accumulation to signed 40-bit range |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Product, or new accumulator value sign-extended |

## Verification
Directed operands at the signed extremes (0x8000 halfwords, 0x80000000, all ones) separate a correct sign treatment of each 17-bit partial operand from an unsigned or mis-shifted one, and garbage in the ignored upper bits shows whether each mode masks them. Accumulation chains issued on consecutive cycles, alternating private and shared selections across threads, distinguish a correct bank index and back-to-back update from a stale read. Sums driven just past 2^39 with saturation off and on tell wrap from clamp, and a long random mix of modes, threads, operations and gaps checks everything against bench-side arithmetic.

// File: rtl/split_mac_pkg.sv
package split_mac_pkg;

  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam int PART_W = HALF_W + 1;
  localparam int PROD_W = 2 * PART_W;
  localparam int FULL_W = 2 * DATA_W;

  typedef enum logic [1:0] {
    MODE_MUL16  = 2'd0,
    MODE_DUAL16 = 2'd1,
    MODE_MUL31  = 2'd2,
    MODE_MUL32  = 2'd3
  } mac_mode_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_SUB  = 2'd2,
    ACC_LOAD = 2'd3
  } acc_op_e;

endpackage

// File: rtl/split_mac_operand.sv
module split_mac_operand
  import split_mac_pkg::*;
(
  input  logic [1:0]               mode,
  input  logic [DATA_W-1:0]        word,
  output logic signed [PART_W-1:0] part_hi,
  output logic signed [PART_W-1:0] part_lo
);

  always_comb begin
    case (mac_mode_e'(mode))
      MODE_MUL16: begin
        part_lo = {word[HALF_W-1], word[HALF_W-1:0]};
        part_hi = '0;
      end
      MODE_DUAL16: begin
        part_lo = {word[HALF_W-1], word[HALF_W-1:0]};
        part_hi = {word[DATA_W-1], word[DATA_W-1:HALF_W]};
      end
      MODE_MUL31: begin
        part_lo = {1'b0, word[HALF_W-1:0]};
        part_hi = {word[DATA_W-2], word[DATA_W-2], word[DATA_W-2:HALF_W]};
      end
      default: begin
        part_lo = {1'b0, word[HALF_W-1:0]};
        part_hi = {word[DATA_W-1], word[DATA_W-1:HALF_W]};
      end
    endcase
  end

endmodule

// File: rtl/split_mac_mul17.sv
module split_mac_mul17
  import split_mac_pkg::*;
(
  input  logic                     clk,
  input  logic                     en,
  input  logic signed [PART_W-1:0] x,
  input  logic signed [PART_W-1:0] y,
  output logic signed [PROD_W-1:0] p
);

  always_ff @(posedge clk) begin
    if (en) p <= x * y;
  end

endmodule

// File: rtl/split_mac_combine.sv
module split_mac_combine
  import split_mac_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input  logic [1:0]               mode,
  input  logic signed [PROD_W-1:0] p_ll,
  input  logic signed [PROD_W-1:0] p_lh,
  input  logic signed [PROD_W-1:0] p_hl,
  input  logic signed [PROD_W-1:0] p_hh,
  output logic [FULL_W-1:0]        product,
  output logic [ACC_W-1:0]         addend
);

  localparam int EXT_W = FULL_W - PROD_W;

  logic signed [FULL_W-1:0] e_ll, e_lh, e_hl, e_hh;
  logic signed [FULL_W-1:0] wide, pair_sum;

  always_comb begin
    e_ll = {{EXT_W{p_ll[PROD_W-1]}}, p_ll};
    e_lh = {{EXT_W{p_lh[PROD_W-1]}}, p_lh};
    e_hl = {{EXT_W{p_hl[PROD_W-1]}}, p_hl};
    e_hh = {{EXT_W{p_hh[PROD_W-1]}}, p_hh};
    wide     = e_ll + ((e_lh + e_hl) <<< HALF_W) + (e_hh <<< DATA_W);
    pair_sum = e_ll + e_hh;
    case (mac_mode_e'(mode))
      MODE_MUL16:  product = e_ll;
      MODE_DUAL16: product = {p_hh[DATA_W-1:0], p_ll[DATA_W-1:0]};
      default:     product = wide;
    endcase
    addend = (mac_mode_e'(mode) == MODE_DUAL16) ? pair_sum[ACC_W-1:0]
                                                : product[ACC_W-1:0];
  end

endmodule

// File: rtl/split_mac_acc_bank.sv
module split_mac_acc_bank
  import split_mac_pkg::*;
#(
  parameter int NUM_ACC = 7,
  parameter int ACC_W   = 40,
  localparam int IDX_W  = $clog2(NUM_ACC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       op,
  input  logic             sat,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] new_val
);

  localparam logic [ACC_W-1:0] MAX_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MAX_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] acc_q [NUM_ACC];
  logic [ACC_W-1:0] base;
  logic [ACC_W:0]   sum;
  logic             ovf;

  always_comb begin
    base = (acc_op_e'(op) == ACC_LOAD) ? '0 : acc_q[idx];
    if (acc_op_e'(op) == ACC_SUB)
      sum = {base[ACC_W-1], base} - {addend[ACC_W-1], addend};
    else
      sum = {base[ACC_W-1], base} + {addend[ACC_W-1], addend};
    ovf = sum[ACC_W] ^ sum[ACC_W-1];
    if (sat && ovf)
      new_val = sum[ACC_W] ? MAX_NEG : MAX_POS;
    else
      new_val = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_ACC; k++) acc_q[k] <= '0;
    end else if (we) begin
      acc_q[idx] <= new_val;
    end
  end

endmodule

// File: rtl/split_mac.sv
module split_mac
  import split_mac_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_SHARED  = 3,
  parameter int ACC_W       = 40,
  localparam int TID_W      = $clog2(NUM_THREADS),
  localparam int SEL_W      = $clog2(NUM_SHARED + 1),
  localparam int NUM_ACC    = NUM_THREADS + NUM_SHARED,
  localparam int IDX_W      = $clog2(NUM_ACC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op_mode,
  input  logic [TID_W-1:0]  thread_id,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic [1:0]        acc_op,
  input  logic              sat_en,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [FULL_W-1:0] result
);

  logic signed [PART_W-1:0] a_hi, a_lo, b_hi, b_lo;
  logic signed [PROD_W-1:0] part_p [4];
  logic [IDX_W-1:0]         idx_in;

  logic             s1_valid, s1_sat;
  logic [1:0]       s1_mode, s1_op;
  logic [IDX_W-1:0] s1_idx;

  logic [FULL_W-1:0] product;
  logic [ACC_W-1:0]  addend, acc_new;
  logic              acc_we;

  split_mac_operand u_split_a (.mode(op_mode), .word(opa), .part_hi(a_hi), .part_lo(a_lo));
  split_mac_operand u_split_b (.mode(op_mode), .word(opb), .part_hi(b_hi), .part_lo(b_lo));

  // Partial product i: operand A half = i/2, operand B half = i%2 (0 low, 1 high)
  for (genvar i = 0; i < 4; i++) begin : g_part
    split_mac_mul17 u_mul (
      .clk (clk),
      .en  (in_valid),
      .x   ((i >= 2)     ? a_hi : a_lo),
      .y   ((i % 2 == 1) ? b_hi : b_lo),
      .p   (part_p[i])
    );
  end

  always_comb begin
    if (acc_sel == '0) idx_in = IDX_W'(thread_id);
    else               idx_in = IDX_W'(NUM_THREADS + int'(acc_sel) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_mode  <= '0;
      s1_op    <= '0;
      s1_sat   <= 1'b0;
      s1_idx   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_mode <= op_mode;
        s1_op   <= acc_op;
        s1_sat  <= sat_en;
        s1_idx  <= idx_in;
      end
    end
  end

  split_mac_combine #(.ACC_W(ACC_W)) u_combine (
    .mode    (s1_mode),
    .p_ll    (part_p[0]),
    .p_lh    (part_p[1]),
    .p_hl    (part_p[2]),
    .p_hh    (part_p[3]),
    .product (product),
    .addend  (addend)
  );

  assign acc_we = s1_valid && (acc_op_e'(s1_op) != ACC_NONE);

  split_mac_acc_bank #(.NUM_ACC(NUM_ACC), .ACC_W(ACC_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (acc_we),
    .idx     (s1_idx),
    .op      (s1_op),
    .sat     (s1_sat),
    .addend  (addend),
    .new_val (acc_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        if (acc_op_e'(s1_op) == ACC_NONE) result <= product;
        else result <= {{(FULL_W-ACC_W){acc_new[ACC_W-1]}}, acc_new};
      end
    end
  end

endmodule

// File: rtl/split_mac_checks.sv
module split_mac_checks
  import split_mac_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        op_mode,
  input logic [1:0]        acc_op,
  input logic              out_valid,
  input logic [FULL_W-1:0] result
);

  // R1: every accepted operation yields a valid result two edges later
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R1: no result appears without an operation two edges earlier
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  // R2: halfword product always fits a signed 32-bit value
  p_mul16_range_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_mode == 2'd0 && acc_op == 2'd0) |-> ##2
      (result[FULL_W-1:DATA_W-1] == '0 || result[FULL_W-1:DATA_W-1] == '1));

  // R4: 31-bit product always fits a signed 62-bit value
  p_mul31_range_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_mode == 2'd2 && acc_op == 2'd0) |-> ##2
      (result[FULL_W-1:FULL_W-3] == '0 || result[FULL_W-1:FULL_W-3] == '1));

  // R6: accumulating operations return a sign-extended accumulator value
  p_acc_extend_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && acc_op != 2'd0) |-> ##2
      (result[FULL_W-1:ACC_W-1] == '0 || result[FULL_W-1:ACC_W-1] == '1));

endmodule

bind split_mac split_mac_checks #(.ACC_W(ACC_W)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_mode   (op_mode),
  .acc_op    (acc_op),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/split_mac_bench.sv
module split_mac_bench;

  localparam int ACC_W = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op_mode = '0;
  logic [1:0]  thread_id = '0;
  logic [1:0]  acc_sel = '0;
  logic [1:0]  acc_op = '0;
  logic        sat_en = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [ACC_W-1:0] acc_m [7];
  logic [63:0]      exp_q [$];
  string            tag_q [$];
  logic [1:0]       vpipe = '0;

  always #4 clk = ~clk;

  split_mac u_split_mac (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_mode(op_mode),
    .thread_id(thread_id), .acc_sel(acc_sel), .acc_op(acc_op), .sat_en(sat_en),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] f_product(logic [1:0] m, logic [31:0] a, logic [31:0] b);
    longint sa, sb;
    int lo, hi;
    case (m)
      2'd0: begin sa = $signed(a[15:0]); sb = $signed(b[15:0]); return sa * sb; end
      2'd1: begin
        lo = $signed(a[15:0]) * $signed(b[15:0]);
        hi = $signed(a[31:16]) * $signed(b[31:16]);
        return {hi, lo};
      end
      2'd2: begin sa = $signed(a[30:0]); sb = $signed(b[30:0]); return sa * sb; end
      default: begin sa = $signed(a); sb = $signed(b); return sa * sb; end
    endcase
  endfunction

  function automatic logic [ACC_W-1:0] f_addend(logic [1:0] m, logic [31:0] a, logic [31:0] b);
    logic [63:0] p;
    longint s;
    p = f_product(m, a, b);
    if (m == 2'd1) begin
      s = longint'($signed(p[31:0])) + longint'($signed(p[63:32]));
      return s[ACC_W-1:0];
    end
    return p[ACC_W-1:0];
  endfunction

  function automatic logic [ACC_W-1:0] f_acc(logic [ACC_W-1:0] base, logic [ACC_W-1:0] x,
                                             logic [1:0] op, logic sat);
    longint bb, xx, s;
    longint lim;
    lim = longint'(1) <<< (ACC_W - 1);
    bb = $signed(base);
    xx = $signed(x);
    if (op == 2'd3)      s = xx;
    else if (op == 2'd2) s = bb - xx;
    else                 s = bb + xx;
    if (sat && s > lim - 1) s = lim - 1;
    if (sat && s < -lim)    s = -lim;
    return s[ACC_W-1:0];
  endfunction

  function automatic string f_tag(logic [1:0] m, logic [1:0] op, logic sat);
    if (op != 2'd0) return sat ? "R9" : "R8";
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic issue(input logic [1:0] m, input int tid, input int sel, input logic [1:0] op,
                       input logic sat, input logic [31:0] a, input logic [31:0] b,
                       input string tag);
    int idx;
    logic [63:0] e;
    @(negedge clk);
    in_valid = 1'b1; op_mode = m; thread_id = 2'(tid); acc_sel = 2'(sel);
    acc_op = op; sat_en = sat; opa = a; opb = b;
    if (op == 2'd0) begin
      e = f_product(m, a, b);
    end else begin
      idx = (sel == 0) ? tid : 4 + sel - 1;
      acc_m[idx] = f_acc(acc_m[idx], f_addend(m, a, b), op, sat);
      e = {{(64-ACC_W){acc_m[idx][ACC_W-1]}}, acc_m[idx]};
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opa = $urandom; opb = $urandom;
    end
  endtask

  // Expected valid delay line per R1 (two edges of latency)
  always @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[0], in_valid};
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (out_valid !== vpipe[1]) begin
        errors++;
        $display("FAIL R1 out_valid: actual=%0b expected=%0b", out_valid, vpipe[1]);
      end
      if (vpipe[1] && exp_q.size() > 0) begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (result !== e) begin
          errors++;
          $display("FAIL %s result: actual=%h expected=%h", t, result, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 7; k++) acc_m[k] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 64'd0) begin
      errors++;
      $display("FAIL R1 reset state: actual=%0b/%h expected=0/0", out_valid, result);
    end
    rst = 1'b0;

    // R2: extreme halfwords, upper bits ignored
    issue(2'd0, 0, 0, 2'd0, 0, 32'hABCD_8000, 32'h1234_8000, "R2");
    issue(2'd0, 0, 0, 2'd0, 0, 32'hFFFF_7FFF, 32'h0000_8000, "R2");
    // R3: dual halfword products
    issue(2'd1, 0, 0, 2'd0, 0, 32'h8000_7FFF, 32'h8000_7FFF, "R3");
    issue(2'd1, 1, 0, 2'd0, 0, 32'hFFFF_0003, 32'h0005_FFFE, "R3");
    // R4: bit 31 ignored, bit 30 is sign
    issue(2'd2, 0, 0, 2'd0, 0, 32'hC000_0000, 32'h0000_0003, "R4");
    issue(2'd2, 0, 0, 2'd0, 0, 32'h4000_0000, 32'hC000_0000, "R4");
    // R5: full 32-bit signed
    issue(2'd3, 0, 0, 2'd0, 0, 32'h8000_0000, 32'h8000_0000, "R5");
    issue(2'd3, 0, 0, 2'd0, 0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R5");
    idle(2);

    // R6 / R10: load, add, subtract back-to-back on thread 0 private
    issue(2'd0, 0, 0, 2'd3, 0, 32'd100, 32'd3, "R6");
    issue(2'd0, 0, 0, 2'd1, 0, 32'd5, 32'd5, "R10");
    issue(2'd3, 0, 0, 2'd2, 0, 32'd7, 32'd4, "R10");
    // R7: another thread's private accumulator is untouched
    issue(2'd0, 2, 0, 2'd1, 0, 32'd0, 32'd0, "R7");
    // R7: shared accumulator 2 written by thread 1, read by thread 3
    issue(2'd0, 1, 2, 2'd3, 0, 32'd1000, 32'd1, "R7");
    issue(2'd0, 3, 2, 2'd1, 0, 32'd1, 32'd1, "R7");
    // R6: no-access op leaves thread 0 private unchanged
    issue(2'd3, 0, 0, 2'd0, 0, 32'h1234_5678, 32'h0000_0010, "R5");
    issue(2'd0, 0, 0, 2'd1, 0, 32'd0, 32'd0, "R6");
    // R6: dual accumulate sums both halfword products (8 + 15)
    issue(2'd1, 1, 0, 2'd3, 0, 32'h0002_0003, 32'h0004_0005, "R6");
    idle(1);

    // R8: 2^38 + 2^38 wraps to -2^39
    issue(2'd3, 0, 1, 2'd3, 0, 32'h0008_0000, 32'h0008_0000, "R8");
    issue(2'd3, 0, 1, 2'd1, 0, 32'h0008_0000, 32'h0008_0000, "R8");
    // R9: clamp at positive and negative limits
    issue(2'd3, 2, 3, 2'd3, 1, 32'h0008_0000, 32'h0008_0000, "R9");
    issue(2'd3, 2, 3, 2'd1, 1, 32'h0008_0000, 32'h0008_0000, "R9");
    issue(2'd3, 2, 3, 2'd1, 1, 32'h0008_0000, 32'h0008_0000, "R9");
    issue(2'd3, 2, 3, 2'd3, 1, 32'hFFF8_0000, 32'h0008_0000, "R9");
    issue(2'd3, 2, 3, 2'd2, 1, 32'h0008_0000, 32'h0008_0000, "R9");
    issue(2'd3, 2, 3, 2'd2, 1, 32'h0008_0000, 32'h0008_0000, "R9");
    idle(2);

    // Random mix of everything, back-to-back with occasional gaps
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] m, op;
      logic s;
      logic [31:0] a, b;
      int tid, sel;
      m = 2'($urandom_range(0, 3));
      op = 2'($urandom_range(0, 3));
      s = 1'($urandom_range(0, 1));
      tid = $urandom_range(0, 3);
      sel = $urandom_range(0, 3);
      a = $urandom;
      b = $urandom;
      if ($urandom_range(0, 3) == 0) a = ($urandom_range(0, 1) == 1) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      if ($urandom_range(0, 3) == 0) b = ($urandom_range(0, 1) == 1) ? 32'hFFFF_FFFF : 32'h8000_8000;
      issue(m, tid, sel, op, s, a, b, f_tag(m, op, s));
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 outstanding results: actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule